// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block places the signals of ten on-chip peripheral functions onto the general-purpose pins of a microcontroller. Any subset of the functions can be switched on through a vector of enable bits. The enabled functions are packed onto the routable pins in a fixed priority order. Packing starts at pin 0. Each enabled function takes a run of consecutive pins that begins right after the pins taken by the enabled functions above it. A routable pin that no enabled function takes is driven from its general-purpose port latch bit. The ports beyond the routable range are always plain general-purpose I/O.

Every pin has its own drive-mode bit that selects push-pull or open-drain drive. A single global bit turns off the weak pull-ups on all pins. Each peripheral signal also gets back the input value of the pin it owns. The configuration inputs (enables, drive modes and pull-up disable) are sampled into internal registers. The pin assignment is computed combinationally from those registers. The block carries no data stream, so every pin is plain level-valued and there is no valid/ready handshake or back-pressure.

Top module: `prio_xbar`

## Requirements
- R1: Pins from index XBAR_PORTS*8 upward (the extra ports, pins 32..63 by default) are never taken by a peripheral. Each of them follows its latch bit under the drive rules of R5 to R7.
- R2: The function order, highest priority first, with its enable bit and signal count, is: bit 0 serial-0 (2), bit 1 SPI (4), bit 2 two-wire bus (2), bit 3 serial-1 (2), bit 4 capture array (6), bit 5 comparators (2), bit 6 timer/interrupt group (4), bit 7 timer 2/4 group (4), bit 8 clock output (1), bit 9 convert-start (1). Signals are numbered in that order, 0 to 27. Signal k of an enabled function goes to pin B+k, where B is the total signal count of the enabled functions above it.
- R3: Every one of the 1024 enable combinations is accepted, and no pin ever has more than one owner.
- R4: A routable pin with no owner takes its latch bit as data, with drive requested.
- R5: The drive-mode bit is 0 for push-pull. A push-pull pin with drive requested has pad_oe_o=1 and pad_o equal to its data. An owned pin whose signal's sig_drive_i bit is 0 is an input, with pad_oe_o=0.
- R6: The drive-mode bit is 1 for open-drain. An open-drain pin drives (pad_oe_o=1) only when its data is 0 and drive is requested, and pad_o is 0 for every open-drain pin.
- R7: pad_pu_o of a pin is 1 exactly when that pin has pad_oe_o=0 and the registered pull-up disable bit is 0.
- R8: sig_in_o of a routed signal equals pad_i of the pin it owns. It is 1 for a signal that is not routed.
- R9: overflow_o is 1 when the enabled signal count exceeds the routable pin count. Signals that do not fit are left unrouted one by one, from the lowest priority upward.
- R10: A change on res_en_i, od_mode_i or pu_dis_i reaches the pins only after the next rising clock edge. Latch, peripheral and pad inputs act combinationally.
- R11: While rst_n is low, all functions are disabled, every drive-mode bit is 1 and the pull-up disable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_en_i | input | 10 | Per-function enable, bit order as in R2 |
| od_mode_i | input | ALL_PINS | Per-pin drive mode, 1 = open-drain |
| pu_dis_i | input | 1 | Global weak pull-up disable |
| port_latch_i | input | ALL_PINS | General-purpose latch bit per pin |
| sig_out_i | input | 28 | Output value of each peripheral signal |
| sig_drive_i | input | 28 | 1 when the peripheral signal drives its pin |
| sig_in_o | output | 28 | Pin value returned to each peripheral signal |
| pad_i | input | ALL_PINS | Value sensed on each pin |
| pad_o | output | ALL_PINS | Output data per pin |
| pad_oe_o | output | ALL_PINS | Output enable per pin |
| pad_pu_o | output | ALL_PINS | Weak pull-up enable per pin |
| overflow_o | output | 1 | Enabled signals exceed routable pins |

## Verification
A wrong running sum in the allocator moves every lower-priority function to other pins. The pad outputs show this combinationally, in the first cycle after the enable register loads, so a sweep over all enable words finds it on the first affected word. A bad register or reset value for the drive modes shows up as open-drain pins driving high or push-pull pins floating, one edge after configuration. A mistake in the input return path shows only on sig_in_o, and only for the routed signals. A truncation error shows only on a smaller routable range, where the enabled signals can outnumber the pins.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;

  localparam int NUM_RES = 10;

  // Signal count of each function, highest priority first.
  function automatic int res_cnt(input int r);
    case (r)
      0: return 2;
      1: return 4;
      2: return 2;
      3: return 2;
      4: return 6;
      5: return 2;
      6: return 4;
      7: return 4;
      8: return 1;
      9: return 1;
      default: return 0;
    endcase
  endfunction

  // Global index of a function's first signal.
  function automatic int res_first(input int r);
    int s;
    s = 0;
    for (int i = 0; i < r; i++) s += res_cnt(i);
    return s;
  endfunction

  localparam int NUM_SIGS = res_first(NUM_RES);

  // Function that owns global signal g.
  function automatic int sig_res(input int g);
    for (int r = 0; r < NUM_RES; r++)
      if (g < res_first(r + 1)) return r;
    return NUM_RES - 1;
  endfunction

endpackage

// File: rtl/prio_xbar_alloc.sv
module prio_xbar_alloc
  import prio_xbar_pkg::*;
#(
  parameter int XPINS = 32,
  parameter int IW    = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_RES-1:0]              en_i,
  output logic [NUM_SIGS-1:0][IW-1:0]     pin_o,
  output logic [NUM_SIGS-1:0]             valid_o,
  output logic                            ovf_o
);

  logic [NUM_RES:0][IW-1:0] base;
  logic [NUM_SIGS-1:0]      want;

  // Running pin count over the enabled functions, in priority order.
  always_comb begin
    base[0] = '0;
    for (int r = 0; r < NUM_RES; r++)
      base[r+1] = base[r] + (en_i[r] ? IW'(res_cnt(r)) : IW'(0));
  end

  for (genvar g = 0; g < NUM_SIGS; g++) begin : g_sig
    localparam int RES = sig_res(g);
    localparam int OFS = g - res_first(RES);
    assign want[g]    = en_i[RES];
    assign pin_o[g]   = base[RES] + IW'(OFS);
    assign valid_o[g] = en_i[RES] && (int'(pin_o[g]) < XPINS);
  end

  assign ovf_o = int'(base[NUM_RES]) > XPINS;

  // R9: the flag agrees with signals that were enabled but not routed
  a_r9_overflow_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> ((want & ~valid_o) != '0));
  a_r9_fit_routes_all: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_o |-> ((want & ~valid_o) == '0));

endmodule

// File: rtl/prio_xbar_route.sv
module prio_xbar_route
  import prio_xbar_pkg::*;
#(
  parameter int XPINS = 32,
  parameter int ALLP  = 64,
  parameter int IW    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SIGS-1:0][IW-1:0] pin_i,
  input  logic [NUM_SIGS-1:0]         valid_i,
  input  logic [NUM_SIGS-1:0]         sig_out_i,
  input  logic [NUM_SIGS-1:0]         sig_drive_i,
  input  logic [ALLP-1:0]             latch_i,
  input  logic [ALLP-1:0]             pad_i,
  output logic [ALLP-1:0]             drv_val_o,
  output logic [ALLP-1:0]             drv_req_o,
  output logic [NUM_SIGS-1:0]         sig_in_o
);

  logic [XPINS-1:0][NUM_SIGS-1:0] hit;

  for (genvar p = 0; p < XPINS; p++) begin : g_xpin
    logic val, req;
    for (genvar g = 0; g < NUM_SIGS; g++) begin : g_cmp
      assign hit[p][g] = valid_i[g] && (pin_i[g] == IW'(p));
    end

    always_comb begin
      val = latch_i[p];
      req = 1'b1;
      for (int g = 0; g < NUM_SIGS; g++) begin
        if (hit[p][g]) begin
          val = sig_out_i[g];
          req = sig_drive_i[g];
        end
      end
    end

    assign drv_val_o[p] = val;
    assign drv_req_o[p] = req;

    // R3: the allocator never hands one pin to two signals
    a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit[p]));
  end

  for (genvar p = XPINS; p < ALLP; p++) begin : g_gpin
    assign drv_val_o[p] = latch_i[p];
    assign drv_req_o[p] = 1'b1;
  end

  always_comb begin
    sig_in_o = '1;
    for (int g = 0; g < NUM_SIGS; g++)
      for (int p = 0; p < XPINS; p++)
        if (hit[p][g]) sig_in_o[g] = pad_i[p];
  end

endmodule

// File: rtl/prio_xbar_pad.sv
module prio_xbar_pad #(
  parameter int ALLP = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ALLP-1:0] drv_val_i,
  input  logic [ALLP-1:0] drv_req_i,
  input  logic [ALLP-1:0] od_i,
  input  logic            pud_i,
  output logic [ALLP-1:0] pad_o,
  output logic [ALLP-1:0] pad_oe_o,
  output logic [ALLP-1:0] pad_pu_o
);

  assign pad_o    = drv_val_i & ~od_i;
  assign pad_oe_o = drv_req_i & (~od_i | ~drv_val_i);
  assign pad_pu_o = {ALLP{~pud_i}} & ~pad_oe_o;

  // R6: an open-drain pin never pushes a high level
  a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (od_i & pad_oe_o & pad_o) == '0);
  // R7: the global disable silences every pull-up
  a_r7_pull_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    pud_i |-> (pad_pu_o == '0));
  // R7: a driven pin has no pull-up
  a_r7_pull_only_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu_o & pad_oe_o) == '0);

endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
  import prio_xbar_pkg::*;
#(
  parameter  int XBAR_PORTS = 4,
  parameter  int GPIO_PORTS = 4,
  localparam int XPINS      = XBAR_PORTS * 8,
  localparam int ALL_PINS   = (XBAR_PORTS + GPIO_PORTS) * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_RES-1:0]  res_en_i,
  input  logic [ALL_PINS-1:0] od_mode_i,
  input  logic                pu_dis_i,
  input  logic [ALL_PINS-1:0] port_latch_i,
  input  logic [NUM_SIGS-1:0] sig_out_i,
  input  logic [NUM_SIGS-1:0] sig_drive_i,
  output logic [NUM_SIGS-1:0] sig_in_o,
  input  logic [ALL_PINS-1:0] pad_i,
  output logic [ALL_PINS-1:0] pad_o,
  output logic [ALL_PINS-1:0] pad_oe_o,
  output logic [ALL_PINS-1:0] pad_pu_o,
  output logic                overflow_o
);

  localparam int IW = $clog2(NUM_SIGS + 1) + 1;

  logic [NUM_RES-1:0]          en_q;
  logic [ALL_PINS-1:0]         od_q;
  logic                        pud_q;
  logic [NUM_SIGS-1:0][IW-1:0] sig_pin;
  logic [NUM_SIGS-1:0]         sig_valid;
  logic [ALL_PINS-1:0]         drv_val, drv_req;

  // R10/R11: configuration is registered, reset to a released state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      od_q  <= '1;
      pud_q <= 1'b0;
    end else begin
      en_q  <= res_en_i;
      od_q  <= od_mode_i;
      pud_q <= pu_dis_i;
    end
  end

  prio_xbar_alloc #(.XPINS(XPINS), .IW(IW)) i_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_q),
    .pin_o   (sig_pin),
    .valid_o (sig_valid),
    .ovf_o   (overflow_o)
  );

  prio_xbar_route #(.XPINS(XPINS), .ALLP(ALL_PINS), .IW(IW)) i_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (sig_pin),
    .valid_i     (sig_valid),
    .sig_out_i   (sig_out_i),
    .sig_drive_i (sig_drive_i),
    .latch_i     (port_latch_i),
    .pad_i       (pad_i),
    .drv_val_o   (drv_val),
    .drv_req_o   (drv_req),
    .sig_in_o    (sig_in_o)
  );

  prio_xbar_pad #(.ALLP(ALL_PINS)) i_pad (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_val_i (drv_val),
    .drv_req_i (drv_req),
    .od_i      (od_q),
    .pud_i     (pud_q),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o),
    .pad_pu_o  (pad_pu_o)
  );

endmodule

// File: tb/test_prio_xbar.sv
module test_prio_xbar;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  en;
  logic [63:0] od, latch, padi;
  logic        pud;
  logic [27:0] sout, sdrv;

  logic [63:0] b_o, b_oe, b_pu;
  logic [27:0] b_sin;
  logic        b_ovf;
  logic [15:0] s_o, s_oe, s_pu;
  logic [27:0] s_sin;
  logic        s_ovf;

  logic [63:0] e_o, e_oe, e_pu;
  logic [27:0] e_sin;
  logic        e_ovf;

  int CNT [10] = '{2, 4, 2, 2, 6, 2, 4, 4, 1, 1};
  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_xbar i_prio_xbar (
    .clk(clk), .rst_n(rst_n), .res_en_i(en), .od_mode_i(od), .pu_dis_i(pud),
    .port_latch_i(latch), .sig_out_i(sout), .sig_drive_i(sdrv), .sig_in_o(b_sin),
    .pad_i(padi), .pad_o(b_o), .pad_oe_o(b_oe), .pad_pu_o(b_pu), .overflow_o(b_ovf)
  );

  prio_xbar #(.XBAR_PORTS(2), .GPIO_PORTS(0)) i_prio_xbar_small (
    .clk(clk), .rst_n(rst_n), .res_en_i(en), .od_mode_i(od[15:0]), .pu_dis_i(pud),
    .port_latch_i(latch[15:0]), .sig_out_i(sout), .sig_drive_i(sdrv), .sig_in_o(s_sin),
    .pad_i(padi[15:0]), .pad_o(s_o), .pad_oe_o(s_oe), .pad_pu_o(s_pu), .overflow_o(s_ovf)
  );

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference packing and pad rules, from the requirements only.
  task automatic model(input int np, input int allp);
    int owner [64];
    int nxt, g;
    logic d, drv;
    for (int i = 0; i < 64; i++) owner[i] = -1;
    nxt = 0;
    g = 0;
    for (int r = 0; r < 10; r++) begin
      for (int k = 0; k < CNT[r]; k++) begin
        if (en[r]) begin
          if (nxt < np) owner[nxt] = g;
          nxt++;
        end
        g++;
      end
    end
    e_ovf = (nxt > np);
    e_sin = '1;
    e_o = '0; e_oe = '0; e_pu = '0;
    for (int p = 0; p < allp; p++) begin
      if (owner[p] >= 0) begin
        d = sout[owner[p]];
        drv = sdrv[owner[p]];
        e_sin[owner[p]] = padi[p];
      end else begin
        d = latch[p];
        drv = 1'b1;
      end
      e_o[p]  = d & ~od[p];
      e_oe[p] = drv & (~od[p] | ~d);
      e_pu[p] = ~pud & ~e_oe[p];
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    en = '1; od = '0; latch = '1; padi = '0; pud = 1'b0; sout = '0; sdrv = '0;
    repeat (3) @(negedge clk);
    // R11: enables cleared, open-drain everywhere, pull-ups on
    chk("R11 reset pads", {b_oe, b_pu, 1'b0}, {64'h0, {64{1'b1}}, 1'b0});
    chk("R11 reset flag", {b_ovf, s_ovf}, 2'b00);
    rst_n = 1'b1;

    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      en    = 10'(v);
      od    = {$urandom(), $urandom()};
      latch = {$urandom(), $urandom()};
      padi  = {$urandom(), $urandom()};
      sout  = 28'($urandom());
      sdrv  = 28'($urandom()) | 28'($urandom());
      pud   = 1'($urandom());
      @(negedge clk);
      model(32, 64);
      chk("R2/R3/R4/R5/R6 pad drive", {b_o[31:0], b_oe[31:0]}, {e_o[31:0], e_oe[31:0]});
      chk("R1 extra ports", {b_o[63:32], b_oe[63:32], b_pu[63:32]},
          {e_o[63:32], e_oe[63:32], e_pu[63:32]});
      chk("R7 pull-ups", b_pu, e_pu);
      chk("R8 input return", b_sin, e_sin);
      chk("R9 flag wide", b_ovf, e_ovf);
      model(16, 16);
      chk("R9 truncation small", {s_o, s_oe, s_pu, s_sin, s_ovf},
          {e_o[15:0], e_oe[15:0], e_pu[15:0], e_sin, e_ovf});
    end

    // R10: an enable change waits for the clock edge
    @(negedge clk);
    en = '0; od = '0; latch = '0; sout = 28'h1; sdrv = 28'h1; pud = 1'b0;
    @(negedge clk);
    chk("R10 before change", {b_o[0], b_oe[0]}, 2'b01);
    en = 10'h001;
    #(CLK_PERIOD/4);
    chk("R10 held until edge", {b_o[0], b_oe[0]}, 2'b01);
    @(negedge clk);
    chk("R10 after edge", {b_o[0], b_oe[0]}, 2'b11);
    od = '1;
    #(CLK_PERIOD/4);
    chk("R10 mode held", {b_o[0], b_oe[0]}, 2'b11);
    @(negedge clk);
    chk("R10 mode after edge R6", {b_o[0], b_oe[0], b_pu[0]}, 3'b001);

    finish_run();
  end

endmodule